// File: doc/BRIEF.md
# Second-Level Interrupt Pending Aggregator

This block collects one-bit interrupt summaries from five sub-systems into one 32-bit pending register. Three of the sub-systems are per-port MAC blocks, one is a switch engine and one is a buffer manager. Each sub-system already masks its own sources, so a summary input reaching this block is already qualified. A rising edge on a summary latches its pending bit. The bit then holds until software reads the pending register, and that read clears every pending bit at once.

A companion mask register chooses which pending bits reach the single event output. That output is the flag that the parent status register samples. Software reaches both registers through a small word-addressed read/write bus. Address 0 is the pending register and address 1 is the mask register. A read presents its data on `bus_rdata` one cycle after the request. The external reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `irq_agg_top`

## Requirements
- R1: Summary `src_sum[0]`, `src_sum[1]` and `src_sum[2]` (port 0, 1 and 2 MAC) map to pending bits 0, 1 and 2. `src_sum[3]` (switch engine) maps to bit 5, and `src_sum[4]` (buffer manager) maps to bit 6.
- R2: Pending bits 31:7 and 4:3 are reserved and always read as 0.
- R3: A pending bit is set on the clock edge where its summary is first sampled high. Holding the summary high does not set the bit again after a clear; only a new 0-to-1 transition does.
- R4: A read of address 0 returns the pending value from before the read, and the same edge clears all pending bits.
- R5: After reset the pending register is 0, the mask register reads 0x0000_0067 (all implemented bits masked), and the event output is 0.
- R6: The mask register at address 1 is read/write on bits 6, 5, 2, 1 and 0. Its other bits ignore writes and read as 0.
- R7: `irq_evt` is a registered level. It is high one cycle after any pending bit is 1 while its mask bit is 0, and low one cycle after no such bit remains.
- R8: A write to address 0 leaves the pending register unchanged.
- R9: If a summary rises in the same cycle as a pending read, the read returns the old value and the bit is set after the read.
- R10: A read of the mask register does not clear any pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request valid for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| src_sum | input | 5 | Per-sub-system unmasked pending summaries |
| irq_evt | output | 1 | Aggregated event to the parent status register |

## Verification
Two functions can fall in the same cycle: a summary's rising edge, which sets a bit, and a pending read, which clears it. The bench provokes the collision by raising the switch-engine summary on the exact edge of a pending read. The result passes only if the returned word lacks bit 5 and a second read shows bit 5 still set. The bench also places a pending write and a mask read next to latched bits, to confirm that neither has the clearing side effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_SRC  = 5;
  localparam int REG_W    = 32;

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;

  // Bit position in the pending word for each summary input.
  function automatic int src_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 5;
      default: return 6;
    endcase
  endfunction

  // Mask of implemented bits, derived from the position table.
  function automatic logic [REG_W-1:0] impl_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  output logic pend_o
);

  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = src_i & ~prev_q;

  always_comb begin
    prev_d = src_i;
    // a new edge wins over a clear in the same cycle
    pend_d = rise | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i && !prev_q) |=> pend_o);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(src_i && !prev_q)) |=> !pend_o);

  assert_collision_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && src_i && !prev_q) |=> pend_o);

  assert_level_no_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && prev_q && src_i) |=> !pend_o);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int            WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= IMPL;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_mask_rsv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~IMPL) == '0);

  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_o));

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W      = REG_W,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_sum,
  output logic              irq_evt
);

  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits());

  logic rst_ni;
  logic rd_pend, rd_any, wr_mask, wr_pend;
  logic [NUM_SRC-1:0] pend_bits;
  logic [DATA_W-1:0]  pend_vec, mask_vec;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               evt_q, evt_d;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  assign rd_any  = bus_en & ~bus_we;
  assign rd_pend = rd_any & (bus_addr == ADDR_W'(ADDR_PEND));
  assign wr_mask = bus_en & bus_we & (bus_addr == ADDR_W'(ADDR_MASK));
  assign wr_pend = bus_en & bus_we & (bus_addr == ADDR_W'(ADDR_PEND));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_ni),
      .src_i  (src_sum[g]),
      .clr_i  (rd_pend),
      .pend_o (pend_bits[g])
    );
  end

  always_comb begin
    pend_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) pend_vec[src_pos(i)] = pend_bits[i];
  end

  irq_mask_reg #(.WIDTH(DATA_W), .IMPL(IMPL)) u_mask (
    .clk    (clk),
    .rst_n  (rst_ni),
    .wr_en  (wr_mask),
    .wdata  (bus_wdata),
    .mask_o (mask_vec)
  );

  // read return path and event level
  always_comb begin
    rdata_d = rdata_q;
    if (rd_any) begin
      case (bus_addr)
        ADDR_W'(ADDR_PEND): rdata_d = pend_vec;
        ADDR_W'(ADDR_MASK): rdata_d = mask_vec;
        default:            rdata_d = '0;
      endcase
    end
    evt_d = |(pend_vec & ~mask_vec);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      evt_q   <= evt_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_evt   = evt_q;

  assert_rsv_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rdata & ~IMPL) == '0);

  assert_evt_rises_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(pend_vec & ~mask_vec)) |=> irq_evt);

  assert_evt_falls_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(|(pend_vec & ~mask_vec)) |=> !irq_evt);

  assert_pend_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_pend && !(|(src_sum & ~$past(src_sum)))) |=> (pend_vec == $past(pend_vec)));

endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [4:0]  src_sum;
  logic        irq_evt;

  int n_checks = 0;
  int n_errors = 0;
  int pos_tab [5] = '{0, 1, 2, 5, 6};
  localparam logic [31:0] IMPL = 32'h0000_0067;

  always #5 clk = ~clk;

  irq_agg_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_sum(src_sum), .irq_evt(irq_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src_sum[idx] = 1'b1;
    @(negedge clk);
    src_sum[idx] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R5 event after reset", {31'b0, irq_evt}, 32'h0);
    bus_rd(2'd0, d); check("R5 pending after reset", d, 32'h0);
    bus_rd(2'd1, d); check("R5 mask after reset", d, IMPL);
  endtask

  task automatic t_bitmap();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      pulse(i);
      bus_rd(2'd0, d);
      check($sformatf("R1 source %0d position", i), d, 32'h1 << pos_tab[i]);
    end
    for (int i = 0; i < 5; i++) pulse(i);
    bus_rd(2'd0, d); check("R2 reserved bits zero with all set", d, IMPL);
    bus_rd(2'd0, d); check("R4 all cleared after read", d, 32'h0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    bus_wr(2'd1, 32'hFFFF_FFFF); bus_rd(2'd1, d); check("R6 mask write all ones", d, IMPL);
    bus_wr(2'd1, 32'h0000_001A); bus_rd(2'd1, d); check("R6 reserved mask bits ignore write", d, 32'h0000_0002);
    bus_wr(2'd1, 32'h0); bus_rd(2'd1, d); check("R6 mask write zero", d, 32'h0);
  endtask

  task automatic t_event();
    logic [31:0] d;
    pulse(0);
    check("R7 event one cycle late", {31'b0, irq_evt}, 32'h0);
    @(negedge clk);
    check("R7 event set", {31'b0, irq_evt}, 32'h1);
    bus_wr(2'd1, 32'h1);
    check("R7 event held one cycle after mask", {31'b0, irq_evt}, 32'h1);
    @(negedge clk);
    check("R7 event dropped by mask", {31'b0, irq_evt}, 32'h0);
    bus_wr(2'd1, 32'h0);
    @(negedge clk);
    check("R7 event back on unmask", {31'b0, irq_evt}, 32'h1);
    bus_rd(2'd0, d);
    check("R7 event held in cycle of clearing read", {31'b0, irq_evt}, 32'h1);
    @(negedge clk);
    check("R7 event dropped after clearing read", {31'b0, irq_evt}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(1); pulse(4);
    bus_rd(2'd0, d); check("R4 read returns set bits", d, 32'h0000_0042);
    bus_rd(2'd0, d); check("R4 second read empty", d, 32'h0);
  endtask

  task automatic t_write_ignored();
    logic [31:0] d;
    pulse(1);
    bus_wr(2'd0, 32'h0);
    bus_rd(2'd0, d); check("R8 write zero to pending ignored", d, 32'h0000_0002);
    bus_wr(2'd0, 32'hFFFF_FFFF);
    bus_rd(2'd0, d); check("R8 write ones to pending ignored", d, 32'h0);
  endtask

  task automatic t_held();
    logic [31:0] d;
    @(negedge clk); src_sum[2] = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(2'd0, d); check("R3 held level sets once", d, 32'h0000_0004);
    bus_rd(2'd0, d); check("R3 held level no relatch", d, 32'h0);
    @(negedge clk); src_sum[2] = 1'b0;
    pulse(2);
    bus_rd(2'd0, d); check("R3 new edge relatches", d, 32'h0000_0004);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; src_sum[3] = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; src_sum[3] = 1'b0;
    check("R9 colliding read returns old value", bus_rdata, 32'h0);
    bus_rd(2'd0, d); check("R9 colliding edge kept", d, 32'h0000_0020);
  endtask

  task automatic t_mask_read();
    logic [31:0] d;
    pulse(0);
    bus_rd(2'd1, d);
    bus_rd(2'd0, d); check("R10 mask read keeps pending", d, 32'h0000_0001);
  endtask

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_sum = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bitmap();
    t_mask_rw();
    t_event();
    t_clear();
    t_write_ignored();
    t_held();
    t_collision();
    t_mask_read();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule